// File: doc/BRIEF.md
# Set-Only Interrupt Mailbox

This block holds one mailbox word that two parties share. An agent on an external bus reads the word and can raise bits in it, but it has no way to lower any bit. Each raised bit can call for an interrupt to the local processors. The local processors acknowledge a message by writing ones to a clear port. They can also raise bits themselves through a set port, and they choose which bits may interrupt them through a mask register.

The external port is the same in host and device operation. It has no mode input, so the set-only rule can never be bypassed. Address decoding and bus framing are done outside the block. The block sees only a one-cycle write strobe with its data word.

When a set and a clear reach the same bit in the same cycle, the set wins. A message that arrives during an acknowledge is therefore never lost. The interrupt line is registered.

Top module: `mbox_bank`

## Requirements
- R1: While rst_ni is low, the mailbox is all zeros, the mask is all ones and irq_o is 0.
- R2: ext_rdata_o and loc_rdata_o show the stored mailbox. A write that is sampled at a rising edge is visible on them right after that edge.
- R3: When ext_wr_i is high, every mailbox bit whose ext_wdata_i bit is 1 becomes 1. The other bits keep their value.
- R4: An external write never clears a bit. Writing zeros leaves the mailbox unchanged.
- R5: When loc_clr_vld_i is high, every bit whose loc_clr_data_i bit is 1 is cleared. This holds unless a set reaches the same bit in that cycle.
- R6: When loc_set_vld_i is high, every bit whose loc_set_data_i bit is 1 becomes 1.
- R7: In the same cycle, a set from either port beats a local clear on the same bit. Bits that are cleared and not set still clear.
- R8: irq_o is registered. After edge k+1 it equals the OR of (mailbox AND mask) as it stood after edge k.
- R9: When loc_mask_we_i is high, the mask loads loc_mask_i. loc_mask_o shows the mask after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_wr_i | input | 1 | External set strobe |
| ext_wdata_i | input | MBOX_W | External bits to set |
| ext_rdata_o | output | MBOX_W | Mailbox value as the external agent reads it |
| loc_clr_vld_i | input | 1 | Local clear strobe |
| loc_clr_data_i | input | MBOX_W | Ones select the bits to clear |
| loc_set_vld_i | input | 1 | Local set strobe |
| loc_set_data_i | input | MBOX_W | Ones select the bits to set |
| loc_mask_we_i | input | 1 | Mask write strobe |
| loc_mask_i | input | MBOX_W | New mask value |
| loc_rdata_o | output | MBOX_W | Mailbox value as the local side reads it |
| loc_mask_o | output | MBOX_W | Current mask |
| irq_o | output | 1 | Registered interrupt to the local processors |

## Verification
The bench drives an external set and a local clear onto overlapping bits in the same cycle. A design that gave priority to the clear would lose the overlapping bits. Writing all zeros from the external side catches a port that copies its data into the word instead of ORing it in, because the word would be wiped. Changing the mask while the mailbox is nonzero, and clearing the last set bit, exposes an interrupt that is unregistered or one cycle late: irq_o would move in the wrong cycle against the scoreboard. A random run mixes all ports to catch bit-slice or merge errors in the full 64-bit word.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int unsigned MBOX_W_DEF = 64;
  parameter bit          IRQ_RST    = 1'b0;
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int unsigned W = mbox_pkg::MBOX_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_wr_i,
  input  logic [W-1:0] ext_wdata_i,
  input  logic         loc_clr_vld_i,
  input  logic [W-1:0] loc_clr_data_i,
  input  logic         loc_set_vld_i,
  input  logic [W-1:0] loc_set_data_i,
  output logic [W-1:0] mbox_o
);
  logic [W-1:0] set_v, clr_v, mbox_q;

  assign set_v = ({W{ext_wr_i}} & ext_wdata_i) | ({W{loc_set_vld_i}} & loc_set_data_i);
  assign clr_v = {W{loc_clr_vld_i}} & loc_clr_data_i;

  // per-bit cell: set dominates clear
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mbox_q[i] <= 1'b0;
      else if (set_v[i]) mbox_q[i] <= 1'b1;
      else if (clr_v[i]) mbox_q[i] <= 1'b0;
    end
  end

  assign mbox_o = mbox_q;

  a_r3_ext_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr_i |=> ((mbox_q & $past(ext_wdata_i)) == $past(ext_wdata_i)));

  a_r4_no_ext_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_clr_vld_i |=> (($past(mbox_q) & ~mbox_q) == '0));

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_clr_vld_i && !ext_wr_i && !loc_set_vld_i) |=> ((mbox_q & $past(loc_clr_data_i)) == '0));

  a_r6_loc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_set_vld_i |=> ((mbox_q & $past(loc_set_data_i)) == $past(loc_set_data_i)));

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_wr_i && loc_clr_vld_i) |=>
      ((mbox_q & $past(ext_wdata_i & loc_clr_data_i)) == $past(ext_wdata_i & loc_clr_data_i)));
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int unsigned W = mbox_pkg::MBOX_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] mbox_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= mbox_pkg::IRQ_RST;
    else         irq_q <= |(mbox_i & mask_q);
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  a_r9_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_i)));

  a_r9_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));

  a_r8_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_q);

  a_r8_irq_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_i == '0) |=> !irq_q);
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int unsigned MBOX_W = mbox_pkg::MBOX_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_wr_i,
  input  logic [MBOX_W-1:0] ext_wdata_i,
  output logic [MBOX_W-1:0] ext_rdata_o,
  input  logic              loc_clr_vld_i,
  input  logic [MBOX_W-1:0] loc_clr_data_i,
  input  logic              loc_set_vld_i,
  input  logic [MBOX_W-1:0] loc_set_data_i,
  input  logic              loc_mask_we_i,
  input  logic [MBOX_W-1:0] loc_mask_i,
  output logic [MBOX_W-1:0] loc_rdata_o,
  output logic [MBOX_W-1:0] loc_mask_o,
  output logic              irq_o
);
  logic [MBOX_W-1:0] mbox_w;

  mbox_store #(.W(MBOX_W)) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ext_wr_i       (ext_wr_i),
    .ext_wdata_i    (ext_wdata_i),
    .loc_clr_vld_i  (loc_clr_vld_i),
    .loc_clr_data_i (loc_clr_data_i),
    .loc_set_vld_i  (loc_set_vld_i),
    .loc_set_data_i (loc_set_data_i),
    .mbox_o         (mbox_w)
  );

  mbox_irq #(.W(MBOX_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mbox_i    (mbox_w),
    .mask_we_i (loc_mask_we_i),
    .mask_i    (loc_mask_i),
    .mask_o    (loc_mask_o),
    .irq_o     (irq_o)
  );

  assign ext_rdata_o = mbox_w;
  assign loc_rdata_o = mbox_w;

  a_r2_views_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rdata_o == loc_rdata_o);

  a_r8_irq_needs_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(ext_rdata_o & loc_mask_o) != '0));
endmodule

// File: tb/sim_mbox_bank.sv
module sim_mbox_bank;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ext_wr = 1'b0, clr_v = 1'b0, set_v = 1'b0, mask_we = 1'b0;
  logic [W-1:0] ext_wd = '0, clr_d = '0, set_d = '0, mask_d = '0;
  logic [W-1:0] ext_rd, loc_rd, mask_o;
  logic         irq;

  int n_chk = 0, n_bad = 0;

  typedef struct {
    string        tag;
    logic [W-1:0] mb;
    logic [W-1:0] mk;
    logic         iq;
  } exp_t;
  exp_t sb_q[$];

  logic [W-1:0] m_mb = '0, m_mk = '1;

  always #5 clk = ~clk;

  mbox_bank #(.MBOX_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ext_wr_i(ext_wr), .ext_wdata_i(ext_wd), .ext_rdata_o(ext_rd),
    .loc_clr_vld_i(clr_v), .loc_clr_data_i(clr_d),
    .loc_set_vld_i(set_v), .loc_set_data_i(set_d),
    .loc_mask_we_i(mask_we), .loc_mask_i(mask_d),
    .loc_rdata_o(loc_rd), .loc_mask_o(mask_o), .irq_o(irq)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, then push the expected result
  task automatic step(string tag, logic ew, logic [W-1:0] ewd, logic cv, logic [W-1:0] cd,
                      logic sv, logic [W-1:0] sd, logic mw, logic [W-1:0] md);
    exp_t e;
    logic [W-1:0] nmb;
    logic iq;
    @(negedge clk);
    ext_wr = ew; ext_wd = ewd; clr_v = cv; clr_d = cd;
    set_v = sv; set_d = sd; mask_we = mw; mask_d = md;
    @(posedge clk);
    iq  = |(m_mb & m_mk);
    nmb = (m_mb & ~(cv ? cd : '0)) | (ew ? ewd : '0) | (sv ? sd : '0);
    m_mb = nmb;
    if (mw) m_mk = md;
    e.tag = tag; e.mb = m_mb; e.mk = m_mk; e.iq = iq;
    sb_q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(tag, 0, '0, 0, '0, 0, '0, 0, '0);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " R2 ext view"}, ext_rd, e.mb);
        chk({e.tag, " R2 loc view"}, loc_rd, e.mb);
        chk({e.tag, " R9 mask"}, mask_o, e.mk);
        chk({e.tag, " R8 irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, e.iq});
      end
    end
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #23;
    chk("R1 mbox", ext_rd, '0);
    chk("R1 mask", mask_o, '1);
    chk("R1 irq", {63'd0, irq}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
    step("R3", 1, 64'h0000_0000_0000_00F0, 0, '0, 0, '0, 0, '0);
    step("R3", 1, 64'h0F00_0000_0000_0000, 0, '0, 0, '0, 0, '0);
    idle("R8");
    step("R4", 1, '0, 0, '0, 0, '0, 0, '0);
    step("R4", 1, 64'h0000_0000_0000_0030, 0, '0, 0, '0, 0, '0);
    step("R5", 0, '0, 1, 64'h0000_0000_0000_00C0, 0, '0, 0, '0);
    step("R6", 0, '0, 0, '0, 1, 64'h8000_0000_0000_0001, 0, '0);
    step("R7", 1, 64'h0000_0000_0000_0003, 1, 64'h0000_0000_0000_00FF, 0, '0, 0, '0);
    step("R7", 0, '0, 1, 64'h8000_0000_0000_0000, 1, 64'h8000_0000_0000_0000, 0, '0);
    step("R9", 0, '0, 0, '0, 0, '0, 1, '0);
    idle("R8");
    idle("R8");
    step("R9", 0, '0, 0, '0, 0, '0, 1, 64'h0000_0000_0000_0001);
    idle("R8");
    step("R5", 0, '0, 1, '1, 0, '0, 0, '0);
    idle("R8");
    idle("R8");
    for (int i = 0; i < 60; i++) begin
      step("R2", 1'($urandom), {$urandom, $urandom}, 1'($urandom), {$urandom, $urandom},
           1'($urandom), {$urandom, $urandom}, ($urandom % 4) == 0, {$urandom, $urandom});
    end
    idle("R8");
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule